// File: doc/BRIEF.md
# Associative Page Address Translator

This block turns a 24-bit operand address into a location in core memory. Core is split into pages of 512 words. Each page has one register that holds the number of the block now resident in that page, plus a valid flag. A lookup compares the block number in the address against every page register at once. The page that matches supplies the physical page index, and the low address bits supply the word offset inside that page. This is an inverted page table: there is one content-matched entry per physical page, so no table walk happens.

The same decode also splits off three other fields. The top address bit selects the executive store, which skips the compare altogether. The three bottom bits select one of eight 6-bit characters in a 48-bit word. The most significant of those three bits also selects the half-word for 24-bit operations. When no valid page holds the block, the block raises a miss interrupt so that supervisory software can fetch the block. That software then loads page registers through a simple write port.

The result is registered, so it appears one cycle after the request, qualified by an output-valid strobe.

Top module: `assoc_xlate`

## Requirements
- R1: The address fields are decoded as follows. Bits [2:0] are the character select and come out on `out_char`. Bit 2 is also the half-word select and comes out on `out_half`. Bits [11:3] are the word position and come out on `out_offset`. Bits [22:12] are the block number. Bit 23 is the executive-store select.
- R2: A request accepted with `req_valid` high at a clock edge produces `out_valid` high, with all result fields, at the next edge. `out_valid` is low in every cycle that follows a cycle with no request.
- R3: Reset clears every page's valid flag. Any main-memory lookup made after reset and before any page write reports a miss. Right after reset, `out_valid`, `miss_irq` and `multi_hit` are low and `out_status` is 2'b00.
- R4: When `wr_en` is high at a clock edge, page `wr_page` takes `wr_block` as its block number and `wr_valid` as its valid flag. The write affects lookups made in later cycles.
- R5: A main-memory lookup whose block number equals the register of a valid page reports `out_status` 2'b01 (hit). `out_page` is that page's index.
- R6: A main-memory lookup with no valid matching page reports `out_status` 2'b10 (miss). `miss_irq` is high in that output cycle and `out_page` is 0.
- R7: A page whose valid flag is clear never matches, even when its register equals the block number.
- R8: When several valid pages match, the lowest-numbered one is reported and `multi_hit` is high in that output cycle. With a single match, `multi_hit` is low.
- R9: An address with bit 23 set reports `out_status` 2'b11 (executive). `out_exec` is high, `out_page` is 0, and `miss_irq` stays low whatever the page registers hold.
- R10: A lookup in the same cycle as a page write is judged against the page contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 24 | Operand address to translate |
| wr_en | input | 1 | Page register write strobe |
| wr_page | input | PIDX_W (5) | Index of the page to write |
| wr_block | input | 11 | Block number to store in the page |
| wr_valid | input | 1 | Valid flag to store in the page |
| out_valid | output | 1 | Result strobe, one cycle after a request |
| out_status | output | 2 | 00 idle, 01 hit, 10 miss, 11 executive |
| out_page | output | PIDX_W (5) | Physical page index on a hit |
| out_offset | output | 9 | Word position inside the page |
| out_half | output | 1 | Half-word select |
| out_char | output | 3 | Character select |
| out_exec | output | 1 | Executive-store access |
| miss_irq | output | 1 | Miss interrupt request to supervisory software |
| multi_hit | output | 1 | More than one valid page matched |

## Verification
A page write and a lookup can land in the same cycle. The lookup may target the very page being written, or a block that the write is about to make resident or evict. The bench provokes this by raising `wr_en` and `req_valid` on the same edge, once for a block that the write makes resident. It then judges the result one cycle later: that result must still reflect the old contents, which gives a miss. A follow-up lookup of the same address must then reflect the new contents, which gives a hit on the written page.

// File: rtl/assoc_xlate.sv
module assoc_xlate #(
  parameter int NPAGES = 32,
  parameter int BLK_W  = 11,
  parameter int POS_W  = 9,
  parameter int CHR_W  = 3,
  localparam int ADDR_W = 1 + BLK_W + POS_W + CHR_W,
  localparam int PIDX_W = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_page,
  input  logic [BLK_W-1:0]  wr_block,
  input  logic              wr_valid,
  output logic              out_valid,
  output logic [1:0]        out_status,
  output logic [PIDX_W-1:0] out_page,
  output logic [POS_W-1:0]  out_offset,
  output logic              out_half,
  output logic [CHR_W-1:0]  out_char,
  output logic              out_exec,
  output logic              miss_irq,
  output logic              multi_hit
);

  localparam logic [1:0] ST_IDLE = 2'b00;
  localparam logic [1:0] ST_HIT  = 2'b01;
  localparam logic [1:0] ST_MISS = 2'b10;
  localparam logic [1:0] ST_EXEC = 2'b11;

  logic [BLK_W-1:0] pg_blk [NPAGES];
  logic [NPAGES-1:0] pg_vld;

  wire              in_exec = req_addr[ADDR_W-1];
  wire [BLK_W-1:0]  in_blk  = req_addr[ADDR_W-2 -: BLK_W];
  wire [POS_W-1:0]  in_pos  = req_addr[CHR_W +: POS_W];
  wire [CHR_W-1:0]  in_chr  = req_addr[CHR_W-1:0];

  logic              found, dup;
  logic [PIDX_W-1:0] win;

  always_comb begin
    found = 1'b0;
    dup   = 1'b0;
    win   = '0;
    for (int i = 0; i < NPAGES; i++) begin
      if (pg_vld[i] && pg_blk[i] == in_blk) begin
        if (found) dup = 1'b1;
        else begin
          found = 1'b1;
          win   = PIDX_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_vld <= '0;
      for (int i = 0; i < NPAGES; i++) pg_blk[i] <= '0;
    end else if (wr_en) begin
      pg_blk[wr_page] <= wr_block;
      pg_vld[wr_page] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_status <= ST_IDLE;
      out_page   <= '0;
      out_offset <= '0;
      out_char   <= '0;
      miss_irq   <= 1'b0;
      multi_hit  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      miss_irq  <= 1'b0;
      multi_hit <= 1'b0;
      if (req_valid) begin
        out_offset <= in_pos;
        out_char   <= in_chr;
        if (in_exec) begin
          out_status <= ST_EXEC;
          out_page   <= '0;
        end else if (found) begin
          out_status <= ST_HIT;
          out_page   <= win;
          multi_hit  <= dup;
        end else begin
          out_status <= ST_MISS;
          out_page   <= '0;
          miss_irq   <= 1'b1;
        end
      end else begin
        out_status <= ST_IDLE;
      end
    end
  end

  assign out_half = out_char[CHR_W-1];
  assign out_exec = (out_status == ST_EXEC);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R2
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && out_status == ST_IDLE);

  // R1
  char_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_char == $past(req_addr[CHR_W-1:0]) && out_offset == $past(req_addr[CHR_W +: POS_W]));

  // R6
  miss_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_irq |-> out_valid && out_status == ST_MISS && out_page == '0);

  // R8
  multi_only_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |-> out_valid && out_status == ST_HIT);

  // R9
  exec_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[ADDR_W-1]) |=> out_exec && !miss_irq && !multi_hit);

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> pg_vld == '0 && !out_valid && !miss_irq);

endmodule

// File: tb/assoc_xlate_bench.sv
module assoc_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPAGES = 32;
  localparam int PIDX_W = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [23:0] req_addr;
  logic        wr_en;
  logic [PIDX_W-1:0] wr_page;
  logic [10:0] wr_block;
  logic        wr_valid;
  logic        out_valid;
  logic [1:0]  out_status;
  logic [PIDX_W-1:0] out_page;
  logic [8:0]  out_offset;
  logic        out_half;
  logic [2:0]  out_char;
  logic        out_exec;
  logic        miss_irq;
  logic        multi_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_xlate #(.NPAGES(NPAGES)) u_assoc_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .wr_en(wr_en), .wr_page(wr_page), .wr_block(wr_block), .wr_valid(wr_valid),
    .out_valid(out_valid), .out_status(out_status), .out_page(out_page),
    .out_offset(out_offset), .out_half(out_half), .out_char(out_char),
    .out_exec(out_exec), .miss_irq(miss_irq), .multi_hit(multi_hit));

  function automatic logic [23:0] mk(input logic e, input logic [10:0] b,
                                     input logic [8:0] p, input logic [2:0] c);
    return {e, b, p, c};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_page(input int pg, input logic [10:0] b, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_page = PIDX_W'(pg); wr_block = b; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [23:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R3", "out_valid", 32'(out_valid), 0);
    check("R3", "status", 32'(out_status), 0);
    check("R3", "irq", 32'(miss_irq), 0);
    check("R3", "multi", 32'(multi_hit), 0);
    lookup(mk(1'b0, 11'h000, 9'h000, 3'd0));
    check("R3", "status after reset", 32'(out_status), 32'h2);
    check("R3", "irq after reset", 32'(miss_irq), 1);
  endtask

  task automatic t_hit_decode;
    write_page(5, 11'h123, 1'b1);
    lookup(mk(1'b0, 11'h123, 9'h1A5, 3'd5));
    check("R5", "status", 32'(out_status), 32'h1);
    check("R5", "page", 32'(out_page), 5);
    check("R4", "irq", 32'(miss_irq), 0);
    check("R1", "offset", 32'(out_offset), 32'h1A5);
    check("R1", "char", 32'(out_char), 5);
    check("R1", "half", 32'(out_half), 1);
    check("R2", "valid", 32'(out_valid), 1);
    @(negedge clk);
    check("R2", "valid drops", 32'(out_valid), 0);
    lookup(mk(1'b0, 11'h123, 9'h002, 3'd2));
    check("R1", "char2", 32'(out_char), 2);
    check("R1", "half0", 32'(out_half), 0);
    check("R1", "offset2", 32'(out_offset), 2);
  endtask

  task automatic t_miss;
    lookup(mk(1'b0, 11'h124, 9'h010, 3'd1));
    check("R6", "status", 32'(out_status), 32'h2);
    check("R6", "irq", 32'(miss_irq), 1);
    check("R6", "page", 32'(out_page), 0);
  endtask

  task automatic t_multi_and_invalid;
    write_page(3, 11'h123, 1'b1);
    lookup(mk(1'b0, 11'h123, 9'h0FF, 3'd0));
    check("R8", "page lowest", 32'(out_page), 3);
    check("R8", "multi", 32'(multi_hit), 1);
    write_page(3, 11'h123, 1'b0);
    lookup(mk(1'b0, 11'h123, 9'h0FF, 3'd0));
    check("R7", "page skips invalid", 32'(out_page), 5);
    check("R7", "multi", 32'(multi_hit), 0);
    write_page(5, 11'h123, 1'b0);
    lookup(mk(1'b0, 11'h123, 9'h0FF, 3'd0));
    check("R7", "all invalid miss", 32'(out_status), 32'h2);
  endtask

  task automatic t_exec;
    write_page(9, 11'h055, 1'b1);
    lookup(mk(1'b1, 11'h055, 9'h033, 3'd6));
    check("R9", "status", 32'(out_status), 32'h3);
    check("R9", "exec", 32'(out_exec), 1);
    check("R9", "irq", 32'(miss_irq), 0);
    check("R9", "page", 32'(out_page), 0);
    lookup(mk(1'b1, 11'h700, 9'h000, 3'd0));
    check("R9", "unmapped irq", 32'(miss_irq), 0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_page = PIDX_W'(NPAGES-1); wr_block = 11'h7FF; wr_valid = 1'b1;
    req_valid = 1'b1; req_addr = mk(1'b0, 11'h7FF, 9'h1FF, 3'd7);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R10", "old contents miss", 32'(out_status), 32'h2);
    lookup(mk(1'b0, 11'h7FF, 9'h1FF, 3'd7));
    check("R10", "new contents hit", 32'(out_status), 32'h1);
    check("R4", "top page", 32'(out_page), NPAGES-1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    wr_en = 1'b0; wr_page = '0; wr_block = '0; wr_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_hit_decode;
    t_miss;
    t_multi_and_invalid;
    t_exec;
    t_same_cycle;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule